// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Readout

This block holds the digital side of a 12-bit successive-approximation converter. Five synchronous control inputs do two jobs: they start conversions and they open the output lines for reading. The inputs are a chip enable, an active-low chip select, a read/convert line, a word-format select and an address bit. A conversion starts on any one of three edge conditions. At that moment the address bit is captured. It sets the conversion length to either the full width or a short 8-bit run. A busy flag is held high for the whole conversion.

The built-in sequencer resolves one bit per clock, starting with the most significant bit. It presents a trial code for an external DAC. A 1-bit comparator answer decides whether each trial bit is kept. For a read, the result can be presented in two ways:
- as one full word on all lines, or
- as two left-justified bytes on the upper eight lines: first the high byte, then the low nibble followed by zero bits.

Lines that are not enabled are reported as such on a separate enable vector, which stands in for tri-state buffers.

Top module: `sar_ctl_readout`

## Requirements
- R1: After reset is released, `busy_o` is 0 and `db_oe_o` is all zero, and no conversion begins until a start condition occurs.
- R2: A rising edge of `ce_i` (sampled from one clock to the next) while `cs_n_i`=0 and `rc_i`=0 starts a conversion. `busy_o` is 1 from the next clock edge onward.
- R3: A falling edge of `cs_n_i` while `ce_i`=1 and `rc_i`=0 starts a conversion.
- R4: A falling edge of `rc_i` while `ce_i`=1 and `cs_n_i`=0 starts a conversion. With `ce_i`=1, `cs_n_i`=0, `a0_i`=0 and `fmt12_i`=1 held, toggling `rc_i` alone gives full conversions and full-word reads.
- R5: While `ce_i`=0 or `cs_n_i`=1, no edge on any input starts a conversion, and `db_oe_o` is all zero.
- R6: `a0_i` is captured at the start edge. A value of 0 gives a conversion during which `busy_o` stays high for 12 clocks; a value of 1 gives 8 clocks. Changes of `a0_i` during a conversion do not alter its length.
- R7: The sequencer decides bits 11 down to 0, one per clock. During each step, `trial_o` holds the bits decided so far with the current bit set. The bit is kept when `cmp_i`=1, meaning the input is at or above the trial level. A full conversion therefore yields the largest code not exceeding the input.
- R8: After a short conversion, bits 11..4 hold the decided bits, bit 3 reads 1 and bits 2..0 read 0.
- R9: A start condition that occurs while `busy_o`=1 is ignored. The running conversion keeps its length and its result.
- R10: With `ce_i`=1, `cs_n_i`=0, `rc_i`=1 and `fmt12_i`=1, `db_oe_o`=12'hFFF and `db_o` equals the 12-bit result.
- R11: A read with `fmt12_i`=0 and `a0_i`=0 gives `db_oe_o`=12'hFF0 and `db_o`[11:4] equal to result bits 11..4.
- R12: A read with `fmt12_i`=0 and `a0_i`=1 gives `db_oe_o`=12'hFF0, `db_o`[11:8] equal to result bits 3..0 and `db_o`[7:4]=0. In every read, lines with the enable bit at 0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert: low to convert, high to read |
| fmt12_i | input | 1 | Read format: 1 for full word, 0 for 8+4 bytes |
| a0_i | input | 1 | Address bit: short-length select at start, byte select at read |
| cmp_i | input | 1 | Comparator answer: 1 when input is at or above `trial_o` |
| busy_o | output | 1 | High while a conversion runs |
| trial_o | output | 12 | Trial code for the DAC |
| db_o | output | 12 | Output data lines |
| db_oe_o | output | 12 | Per-line output enable |

## Verification
The assertions assume that every control input is synchronous to the clock and is held for at least one cycle. They also assume that `cmp_i` answers the present `trial_o` within the same cycle. The bench keeps to this by:
- changing inputs shortly after a rising edge, and at most one edge-relevant control per cycle;
- modelling the comparator combinationally from `trial_o` against a fixed input code for each conversion;
- reading only after `busy_o` has fallen.

It also brings start conditions in while busy and changes the address bit in the middle of a conversion, to show that both are ignored.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
   // read-path selection derived from the control inputs
   typedef enum logic [1:0] {
      RD_OFF   = 2'd0,
      RD_WORD  = 2'd1,
      RD_UPPER = 2'd2,
      RD_LOWER = 2'd3
   } rd_mode_e;
endpackage

// File: rtl/sar_ctl_trig.sv
module sar_ctl_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic cs_n_i,
   input  logic rc_i,
   output logic trig_o
);
   logic ce_q, cs_n_q, rc_q;

   // previous levels reset to "already asserted" so release is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b1;
         cs_n_q <= 1'b0;
         rc_q   <= 1'b0;
      end else begin
         ce_q   <= ce_i;
         cs_n_q <= cs_n_i;
         rc_q   <= rc_i;
      end
   end

   logic ce_rise, cs_fall, rc_fall;
   assign ce_rise = ce_i & ~ce_q;
   assign cs_fall = ~cs_n_i & cs_n_q;
   assign rc_fall = ~rc_i & rc_q;

   assign trig_o = (ce_rise & ~cs_n_i & ~rc_i)
                 | (cs_fall &  ce_i   & ~rc_i)
                 | (rc_fall &  ce_i   & ~cs_n_i);
endmodule

// File: rtl/sar_ctl_seq.sv
module sar_ctl_seq #(
   parameter int DATA_W  = 12,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              a0_i,
   input  logic              cmp_i,
   output logic              busy_o,
   output logic              short_o,
   output logic [DATA_W-1:0] trial_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int LSB_W = DATA_W - SHORT_W;
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [LSB_W-1:0] TAIL = LSB_W'(1) << (LSB_W - 1);

   logic              busy_q, short_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [DATA_W-1:0] res_q;
   logic [IDX_W-1:0]  stop_idx;

   assign stop_idx = short_q ? IDX_W'(LSB_W) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         short_q <= 1'b0;
         ptr_q   <= '0;
         res_q   <= '0;
      end else if (!busy_q) begin
         if (trig_i) begin
            busy_q  <= 1'b1;
            short_q <= a0_i;
            ptr_q   <= IDX_W'(DATA_W - 1);
            res_q   <= '0;
         end
      end else begin
         res_q[ptr_q] <= cmp_i;
         if (ptr_q == stop_idx) begin
            busy_q <= 1'b0;
            if (short_q) res_q[LSB_W-1:0] <= TAIL;
         end else begin
            ptr_q <= ptr_q - 1'b1;
         end
      end
   end

   always_comb begin
      trial_o = res_q;
      if (busy_q) trial_o[ptr_q] = 1'b1;
   end

   assign busy_o  = busy_q;
   assign short_o = short_q;
   assign data_o  = res_q;

   // busy-length window counter for the checks below
   logic [IDX_W:0] cyc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc_q <= '0;
      else if (!busy_q) cyc_q <= '0;
      else              cyc_q <= cyc_q + 1'b1;
   end

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (cyc_q == (short_q ? (IDX_W+1)'(SHORT_W) : (IDX_W+1)'(DATA_W))));

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && trig_i) |=> (!busy_q || ptr_q != IDX_W'(DATA_W - 1)));

   // R8
   short_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && short_q) |-> (res_q[LSB_W-1:0] == TAIL));
endmodule

// File: rtl/sar_ctl_rdout.sv
module sar_ctl_rdout
   import sar_ctl_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              cs_n_i,
   input  logic              rc_i,
   input  logic              fmt12_i,
   input  logic              a0_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] db_o,
   output logic [DATA_W-1:0] db_oe_o
);
   localparam int LSB_W = DATA_W - SHORT_W;
   localparam int PAD_W = SHORT_W - LSB_W;

   rd_mode_e mode;
   always_comb begin
      if (!(ce_i && !cs_n_i && rc_i)) mode = RD_OFF;
      else if (fmt12_i)               mode = RD_WORD;
      else if (a0_i)                  mode = RD_LOWER;
      else                            mode = RD_UPPER;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      logic en, val;
      if (i >= LSB_W) begin : g_up
         localparam int J = i - LSB_W;
         logic low_bit;
         if (J >= PAD_W) begin : g_tail
            assign low_bit = data_i[J-PAD_W];
         end else begin : g_pad
            assign low_bit = 1'b0;
         end
         assign en  = (mode != RD_OFF);
         assign val = (mode == RD_LOWER) ? low_bit : data_i[i];
      end else begin : g_lo
         assign en  = (mode == RD_WORD);
         assign val = data_i[i];
      end
      assign db_oe_o[i] = en;
      assign db_o[i]    = en & val;
   end

   // R5
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_i || cs_n_i) |-> (db_oe_o == '0));

   // R11
   byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && !cs_n_i && rc_i && !fmt12_i) |->
         (db_oe_o[LSB_W-1:0] == '0 && (&db_oe_o[DATA_W-1:LSB_W])));

   // R12
   trail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && !cs_n_i && rc_i && !fmt12_i && a0_i) |-> (db_o[SHORT_W-1:LSB_W] == '0));
endmodule

// File: rtl/sar_ctl_readout.sv
module sar_ctl_readout #(
   parameter int DATA_W  = 12,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              cs_n_i,
   input  logic              rc_i,
   input  logic              fmt12_i,
   input  logic              a0_i,
   input  logic              cmp_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] trial_o,
   output logic [DATA_W-1:0] db_o,
   output logic [DATA_W-1:0] db_oe_o
);
   if (SHORT_W >= DATA_W || 2 * SHORT_W <= DATA_W) begin : g_bad_width
      $error("sar_ctl_readout: SHORT_W must lie strictly between DATA_W/2 and DATA_W");
   end

   logic              trig, short_len;
   logic [DATA_W-1:0] result;

   sar_ctl_trig i_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_i   (ce_i),
      .cs_n_i (cs_n_i),
      .rc_i   (rc_i),
      .trig_o (trig)
   );

   sar_ctl_seq #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig),
      .a0_i    (a0_i),
      .cmp_i   (cmp_i),
      .busy_o  (busy_o),
      .short_o (short_len),
      .trial_o (trial_o),
      .data_o  (result)
   );

   sar_ctl_rdout #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_rdout (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_i    (ce_i),
      .cs_n_i  (cs_n_i),
      .rc_i    (rc_i),
      .fmt12_i (fmt12_i),
      .a0_i    (a0_i),
      .data_i  (result),
      .db_o    (db_o),
      .db_oe_o (db_oe_o)
   );

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !busy_o) |=> busy_o);

   // R6
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(short_len));
endmodule

// File: tb/test_sar_ctl_readout.sv
`timescale 1ns/1ps
module test_sar_ctl_readout;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce, cs_n, rc, fmt12, a0;
   logic [11:0] vin;
   logic [11:0] trial, db, db_oe;
   logic busy, cmp;

   always #10 clk = ~clk;

   assign cmp = (trial <= vin);

   sar_ctl_readout i_sar_ctl_readout (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc),
      .fmt12_i(fmt12), .a0_i(a0), .cmp_i(cmp), .busy_o(busy),
      .trial_o(trial), .db_o(db), .db_oe_o(db_oe)
   );

   int n_run = 0;
   int n_fail = 0;

   typedef struct {
      logic [11:0] db;
      logic [11:0] oe;
      string       tag;
   } item_t;
   item_t sb_q[$];
   logic  mon_stb = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected read and compares at the negedge
   always @(negedge clk) begin
      if (mon_stb && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check(db_oe == it.oe, {it.tag, " enable"}, int'(db_oe), int'(it.oe));
         check(db == it.db,    {it.tag, " data"},   int'(db),    int'(it.db));
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // driver: push expected read item, present read controls one cycle
   task automatic read_exp(input logic f12, input logic sel, input logic [11:0] word, input string tag);
      item_t it;
      fmt12 = f12; a0 = sel; ce = 1'b1; cs_n = 1'b0; rc = 1'b1;
      if (f12)       begin it.oe = 12'hFFF; it.db = word; end
      else if (!sel) begin it.oe = 12'hFF0; it.db = {word[11:4], 4'h0}; end
      else           begin it.oe = 12'hFF0; it.db = {word[3:0], 8'h00}; end
      it.tag = tag;
      sb_q.push_back(it);
      mon_stb = 1'b1;
      step();
      mon_stb = 1'b0;
   endtask

   // called right after a start condition is driven
   task automatic run_conv(input int len, input string tag, input bit flip_a0, input int glitch);
      int n = 0;
      for (int c = 0; c < len + 4; c++) begin
         @(posedge clk);
         #2;
         if (flip_a0 && c == 1) a0 = ~a0;
         if (glitch >= 0 && c == glitch) rc = 1'b1;
         if (glitch >= 0 && c == glitch + 1) begin rc = 1'b0; a0 = 1'b1; end
         @(negedge clk);
         if (c == 0) check(busy == 1'b1, {tag, " busy after start"}, int'(busy), 1);
         if (busy) n++;
      end
      check(n == len, {tag, " busy length"}, n, len);
      check(busy == 1'b0, {tag, " idle after conversion"}, int'(busy), 0);
      step();
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      ce = 1'b0; cs_n = 1'b1; rc = 1'b1; fmt12 = 1'b1; a0 = 1'b0; vin = 12'h000;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      check(db_oe == 12'h000, "R1 enables after reset", int'(db_oe), 0);
      step();

      // R2: chip-enable rising edge, full length
      rc = 1'b0; step();
      cs_n = 1'b0; step();
      vin = 12'hA5C; ce = 1'b1;
      run_conv(12, "R2", 1'b0, -1);
      read_exp(1'b1, 1'b0, 12'hA5C, "R7 R10 full word");

      // R4: stand-alone, read/convert line alone
      vin = 12'h3F1; rc = 1'b0;
      run_conv(12, "R4", 1'b0, -1);
      read_exp(1'b1, 1'b0, 12'h3F1, "R4 stand-alone word");
      vin = 12'hFFF; rc = 1'b0;
      run_conv(12, "R7 top code", 1'b0, -1);
      read_exp(1'b1, 1'b0, 12'hFFF, "R7 top code word");
      vin = 12'h000; rc = 1'b0;
      run_conv(12, "R7 zero code", 1'b0, -1);
      read_exp(1'b1, 1'b0, 12'h000, "R7 zero code word");

      // R3: chip-select falling edge, short length, A0 moved mid-way (R6)
      cs_n = 1'b1; step();
      rc = 1'b0; step();
      @(negedge clk);
      check(busy == 1'b0, "R5 no start with select high", int'(busy), 0);
      step();
      a0 = 1'b1; vin = 12'h6B7; cs_n = 1'b0;
      run_conv(8, "R3 R6 short", 1'b1, -1);
      read_exp(1'b1, 1'b0, 12'h6B8, "R8 short word readback");
      read_exp(1'b0, 1'b0, 12'h6B8, "R11 high byte");
      read_exp(1'b0, 1'b1, 12'h6B8, "R12 low nibble and zeros");

      // R11/R12 on a full-length result
      a0 = 1'b0; fmt12 = 1'b1; rc = 1'b0; vin = 12'h9C3;
      run_conv(12, "R6 full length", 1'b0, -1);
      read_exp(1'b0, 1'b0, 12'h9C3, "R11 high byte full");
      read_exp(1'b0, 1'b1, 12'h9C3, "R12 low nibble full");

      // R9: start while busy is ignored
      fmt12 = 1'b1; a0 = 1'b0; vin = 12'h5A5; rc = 1'b0;
      run_conv(12, "R9 ignored restart", 1'b0, 3);
      read_exp(1'b1, 1'b0, 12'h5A5, "R9 result kept");

      // R5: chip enable low, edges do nothing and lines stay off
      ce = 1'b0; step();
      cs_n = 1'b1; step();
      rc = 1'b0; step();
      cs_n = 1'b0; step();
      rc = 1'b1; step();
      rc = 1'b0; step();
      @(negedge clk);
      check(busy == 1'b0, "R5 no start with enable low", int'(busy), 0);
      rc = 1'b1;
      @(negedge clk);
      check(db_oe == 12'h000, "R5 read blocked by enable low", int'(db_oe), 0);
      check(db == 12'h000, "R12 disabled lines read zero", int'(db), 0);
      step();
      ce = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      check(db_oe == 12'h000, "R5 read blocked by select high", int'(db_oe), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule